// File: doc/BRIEF.md
# Strobe-Driven Retransmit FIFO

This block is a first-in/first-out buffer of 9-bit words that has no address inputs. A producer writes by pulsing an active-low write strobe, and a consumer reads by pulsing an active-low read strobe. Two ring pointers, each with an extra wrap bit, walk through a storage array whose depth is a power-of-two parameter. Three active-low flags report the fill state: empty, full and half-full. An active-low retransmit input moves the read side back to location zero, so that the words written since reset can be read out again.

The strobes and the retransmit input are asynchronous. All three pass through a two-flop synchroniser into the system clock domain. A one-flop delay then turns each strobe into single-cycle fall and rise pulses. A controller with three small state machines acts on those pulses:
- The mode machine has the states `MODE_RUN` and `MODE_REWIND`. It goes from RUN to REWIND when the synchronised retransmit goes low. It goes back to RUN once retransmit and both strobes are high.
- The write machine goes from `WR_IDLE` to `WR_HELD` on an accepted write fall, and back to `WR_IDLE` on the write rise, which commits the word.
- The read machine goes from `RD_IDLE` to `RD_HELD` on an accepted read fall, and back to `RD_IDLE` on the read rise, which retires the word.

The output bus is modelled as a data word plus an output-enable. The write data input must stay stable until the write rise has been seen in the clock domain, which is three clock edges after the strobe rises.

Top module: `strobe_fifo`

## Requirements
- R1: While reset is low, and on release, both pointers are at location zero, `empty_n`=0, `full_n`=1, `half_n`=1 and `dout_oe`=0.
- R2: Every strobe and the retransmit input take effect on the third rising clock edge after the edge that first samples the new level.
- R3: A read fall that is accepted (FIFO not empty) drives the oldest unread word on `dout` and sets `dout_oe`=1. `dout_oe` returns to 0 when the read rise is processed, and the read pointer advances at that point.
- R4: A write fall that is accepted (FIFO not full) opens a write cycle. The word on `din` is stored when the write rise is processed, and `empty_n` then goes high. Words come out in the order they were written.
- R5: `full_n`=0 exactly while the occupancy (write pointer minus read pointer) equals DEPTH. With no reads after reset, this happens after DEPTH writes.
- R6: `half_n` goes low when a write fall is accepted while the occupancy is already at least DEPTH/2. It goes high when a read rise is processed that leaves the occupancy at DEPTH/2 or less.
- R7: A write fall seen while full is rejected, and its rise stores nothing. A read fall seen while empty leaves `dout_oe` at 0 and the read pointer unchanged.
- R8: While retransmit is low, the read pointer is held at zero and the write pointer is unchanged. `half_n` is then re-evaluated as the write pointer position above DEPTH/2. Any strobe edge during this time is ignored. After retransmit, the words written since reset (up to DEPTH of them) are read again from the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low retransmit request |
| din | input | WIDTH | Write data word |
| dout | output | WIDTH | Read data word, valid while `dout_oe` is high |
| dout_oe | output | 1 | Output enable for `dout` |
| empty_n | output | 1 | Low when no word is stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than half of the storage is in use |

## Verification
Every input change reaches the flags and the output bus on the third rising edge after it is first sampled. Two flops of that delay come from the synchroniser and one from the controller register. The bench drives inputs on falling clock edges and runs a behavioural model that ages each input by the same number of edges. It compares every output against the model on every falling edge. Directed read checks sample `dout` exactly three falling edges after the read strobe drops. The half-full check samples while the write strobe is still low, which shows that the flag moves on the write fall and not on the write rise.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

    // Mode of the controller: normal operation or read-side rewind.
    typedef enum logic {
        MODE_RUN    = 1'b0,
        MODE_REWIND = 1'b1
    } mode_t;

    // Write side: a cycle is open between an accepted fall and its rise.
    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_HELD = 1'b1
    } wr_state_t;

    // Read side: data is on the bus between an accepted fall and its rise.
    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_HELD = 1'b1
    } rd_state_t;

endpackage

// File: rtl/level_sync.sv
module level_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);

    // Synchroniser chain; inactive (high) level is the reset value.
    logic [STAGES-1:0][N-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/edge_pulse.sv
module edge_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic fall,
    output logic rise
);

    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= 1'b1;
        end else begin
            prev <= level;
        end
    end

    // One-clock pulses on each transition of the synchronised strobe.
    assign fall = prev & ~level;
    assign rise = ~prev & level;

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/strobe_fifo_ctrl.sv
module strobe_fifo_ctrl
    import strobe_fifo_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int WIDTH = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_fall,
    input  logic             wr_rise,
    input  logic             rd_fall,
    input  logic             rd_rise,
    input  logic             wr_lvl,
    input  logic             rd_lvl,
    input  logic             rt_lvl,
    input  logic [WIDTH-1:0] rdata,
    output logic             we,
    output logic [AW-1:0]    waddr,
    output logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] dout,
    output logic             dout_oe,
    output logic             empty_n,
    output logic             full_n,
    output logic             half_n
);

    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);
    localparam logic [AW:0] HALF_V  = (AW+1)'(DEPTH / 2);

    mode_t     mode_q, mode_d;
    wr_state_t wr_q, wr_d;
    rd_state_t rd_q, rd_d;

    logic [AW:0]      wptr, rptr, occ, occ_after;
    logic             half_q, oe_q;
    logic [WIDTH-1:0] dout_q;
    logic             live, is_full, is_empty;
    logic             wr_accept, wr_commit, rd_accept, rd_commit;

    assign occ       = wptr - rptr;
    assign is_full   = (occ == DEPTH_V);
    assign is_empty  = (occ == '0);
    assign live      = (mode_q == MODE_RUN) && rt_lvl;
    assign wr_accept = live && (wr_q == WR_IDLE) && wr_fall && !is_full;
    assign wr_commit = live && (wr_q == WR_HELD) && wr_rise;
    assign rd_accept = live && (rd_q == RD_IDLE) && rd_fall && !is_empty;
    assign rd_commit = live && (rd_q == RD_HELD) && rd_rise;
    assign occ_after = occ + (AW+1)'(wr_commit) - (AW+1)'(1);

    // Next-state logic for the three machines.
    always_comb begin
        mode_d = mode_q;
        wr_d   = wr_q;
        rd_d   = rd_q;
        unique case (mode_q)
            MODE_RUN:    if (!rt_lvl) mode_d = MODE_REWIND;
            MODE_REWIND: if (rt_lvl && wr_lvl && rd_lvl) mode_d = MODE_RUN;
        endcase
        if (mode_q == MODE_REWIND) begin
            wr_d = WR_IDLE;
            rd_d = RD_IDLE;
        end else begin
            unique case (wr_q)
                WR_IDLE: if (wr_accept) wr_d = WR_HELD;
                WR_HELD: if (wr_commit) wr_d = WR_IDLE;
            endcase
            unique case (rd_q)
                RD_IDLE: if (rd_accept) rd_d = RD_HELD;
                RD_HELD: if (rd_commit) rd_d = RD_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_RUN;
            wr_q   <= WR_IDLE;
            rd_q   <= RD_IDLE;
        end else begin
            mode_q <= mode_d;
            wr_q   <= wr_d;
            rd_q   <= rd_d;
        end
    end

    // Pointers, flags and output bus.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr   <= '0;
            rptr   <= '0;
            half_q <= 1'b0;
            oe_q   <= 1'b0;
            dout_q <= '0;
        end else if (mode_q == MODE_REWIND) begin
            rptr   <= '0;
            half_q <= (wptr > HALF_V);
            oe_q   <= 1'b0;
        end else begin
            if (wr_commit) wptr <= wptr + 1'b1;
            if (rd_commit) rptr <= rptr + 1'b1;
            if (rd_accept) begin
                dout_q <= rdata;
                oe_q   <= 1'b1;
            end else if (rd_commit) begin
                oe_q   <= 1'b0;
            end
            if (wr_accept && (occ >= HALF_V)) begin
                half_q <= 1'b1;
            end else if (rd_commit && (occ_after <= HALF_V)) begin
                half_q <= 1'b0;
            end
        end
    end

    assign we      = wr_commit;
    assign waddr   = wptr[AW-1:0];
    assign raddr   = rptr[AW-1:0];
    assign dout    = dout_q;
    assign dout_oe = oe_q;
    assign empty_n = ~is_empty;
    assign full_n  = ~is_full;
    assign half_n  = ~half_q;

    // Occupancy never exceeds the storage size.
    p_occ_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH_V)
        else $error("R5 occupancy above depth");

    // A full FIFO keeps its write pointer.
    p_full_blocks_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_full |=> $stable(wptr))
        else $error("R7 write pointer moved while full");

    // An empty FIFO keeps its read pointer during normal operation.
    p_empty_blocks_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && mode_q == MODE_RUN) |=> $stable(rptr))
        else $error("R7 read pointer moved while empty");

    // Rewind never touches the write side.
    p_rewind_keeps_wptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_REWIND) |=> $stable(wptr))
        else $error("R8 write pointer moved during rewind");

    // Half-full only sets in normal mode from a sufficiently filled FIFO.
    p_half_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(half_q) && $past(mode_q) == MODE_RUN) |-> ($past(occ) >= HALF_V))
        else $error("R6 half-full set below half");

    // The output bus is only enabled by a detected read fall.
    p_oe_from_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> $past(rd_fall))
        else $error("R3 output enabled without read edge");

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             rt_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             dout_oe,
    output logic             empty_n,
    output logic             full_n,
    output logic             half_n
);

    localparam int AW      = $clog2(DEPTH);
    localparam int N_IN    = 3;
    localparam int IDX_WR  = 0;
    localparam int IDX_RD  = 1;
    localparam int IDX_RT  = 2;
    localparam int N_EDGE  = 2;

    logic [N_IN-1:0]   lvl;
    logic [N_EDGE-1:0] fall, rise;
    logic              we;
    logic [AW-1:0]     waddr, raddr;
    logic [WIDTH-1:0]  rdata;

    level_sync #(.N(N_IN), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({rt_n, rd_n, wr_n}),
        .sync_out (lvl)
    );

    for (genvar i = 0; i < N_EDGE; i++) begin : g_edge
        edge_pulse u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .level (lvl[i]),
            .fall  (fall[i]),
            .rise  (rise[i])
        );
    end

    fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (rdata)
    );

    strobe_fifo_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fall (fall[IDX_WR]),
        .wr_rise (rise[IDX_WR]),
        .rd_fall (fall[IDX_RD]),
        .rd_rise (rise[IDX_RD]),
        .wr_lvl  (lvl[IDX_WR]),
        .rd_lvl  (lvl[IDX_RD]),
        .rt_lvl  (lvl[IDX_RT]),
        .rdata   (rdata),
        .we      (we),
        .waddr   (waddr),
        .raddr   (raddr),
        .dout    (dout),
        .dout_oe (dout_oe),
        .empty_n (empty_n),
        .full_n  (full_n),
        .half_n  (half_n)
    );

endmodule

// File: tb/tb_strobe_fifo.sv
module tb_strobe_fifo;

    localparam int DEPTH = 16;
    localparam int HALF  = DEPTH / 2;
    localparam int W     = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_n = 1'b1;
    logic         rd_n = 1'b1;
    logic         rt_n = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         dout_oe, empty_n, full_n, half_n;

    strobe_fifo #(.DEPTH(DEPTH), .WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
        .din(din), .dout(dout), .dout_oe(dout_oe),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural model: inputs aged by three clock edges, queue of history.
    bit           w1 = 1, w2 = 1, w3 = 1, r1 = 1, r2 = 1, r3 = 1, t1 = 1, t2 = 1;
    bit           m_rw = 0, m_wh = 0, m_rh = 0, m_half = 0, m_oe = 0;
    logic [W-1:0] m_dout = '0;
    logic [W-1:0] hist[$];
    int           wr_tot = 0, rd_tot = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            w1 = 1; w2 = 1; w3 = 1; r1 = 1; r2 = 1; r3 = 1; t1 = 1; t2 = 1;
            m_rw = 0; m_wh = 0; m_rh = 0; m_half = 0; m_oe = 0; m_dout = '0;
            hist.delete(); wr_tot = 0; rd_tot = 0;
        end else begin
            bit wf, wz, rf, rz, live, wacc, wcom, racc, rcom;
            int occ;
            wf = w3 & ~w2; wz = ~w3 & w2;
            rf = r3 & ~r2; rz = ~r3 & r2;
            live = !m_rw && t2;
            occ = wr_tot - rd_tot;
            if (m_rw) begin
                rd_tot = 0; m_half = (wr_tot > HALF); m_oe = 0; m_wh = 0; m_rh = 0;
            end else begin
                wacc = live && !m_wh && wf && (occ < DEPTH);
                wcom = live && m_wh && wz;
                racc = live && !m_rh && rf && (occ > 0);
                rcom = live && m_rh && rz;
                if (wacc && occ >= HALF) m_half = 1;
                else if (rcom && (occ - 1 + int'(wcom)) <= HALF) m_half = 0;
                if (racc) begin m_dout = hist[rd_tot]; m_oe = 1; end
                else if (rcom) m_oe = 0;
                if (wcom) begin hist.push_back(din); wr_tot++; end
                if (rcom) rd_tot++;
                if (wacc) m_wh = 1; else if (wcom) m_wh = 0;
                if (racc) m_rh = 1; else if (rcom) m_rh = 0;
            end
            m_rw = m_rw ? !(t2 && w2 && r2) : !t2;
            w3 = w2; w2 = w1; w1 = wr_n;
            r3 = r2; r2 = r1; r1 = rd_n;
            t2 = t1; t1 = rt_n;
        end
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(empty_n == ((wr_tot - rd_tot) != 0), "R4", "model empty_n", empty_n, ((wr_tot - rd_tot) != 0));
            check(full_n == ((wr_tot - rd_tot) != DEPTH), "R5", "model full_n", full_n, ((wr_tot - rd_tot) != DEPTH));
            check(half_n == !m_half, "R6", "model half_n", half_n, !m_half);
            check(dout_oe == m_oe, "R3", "model dout_oe", dout_oe, m_oe);
            if (m_oe) check(dout == m_dout, "R3", "model dout", dout, m_dout);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; wr_n = 1; rd_n = 1; rt_n = 1;
        tick(3);
        rst_n = 1;
        tick(2);
    endtask

    task automatic wr_word(input logic [W-1:0] d);
        din = d; wr_n = 0; tick(4);
        wr_n = 1; tick(4);
    endtask

    task automatic rd_word(input logic [W-1:0] exp, input string req);
        rd_n = 0; tick(3);
        check(dout_oe == 1'b1 && dout == exp, req, "read word", {dout_oe, dout}, {1'b1, exp});
        tick(1);
        rd_n = 1; tick(4);
    endtask

    initial begin
        // R1: reset state
        tick(2);
        check(empty_n == 0 && full_n == 1 && half_n == 1 && dout_oe == 0, "R1", "flags in reset",
              {empty_n, full_n, half_n, dout_oe}, 4'b0110);
        rst_n = 1; tick(2);
        check(empty_n == 0 && full_n == 1 && half_n == 1 && dout_oe == 0, "R1", "flags after reset",
              {empty_n, full_n, half_n, dout_oe}, 4'b0110);

        // R4 basic write / read order, R2 latency
        for (int i = 0; i < 3; i++) wr_word(W'(9'h100 + i));
        check(empty_n == 1, "R4", "not empty after writes", empty_n, 1);
        rd_n = 0; tick(2);
        check(dout_oe == 0, "R2", "oe before third edge", dout_oe, 0);
        tick(1);
        check(dout_oe == 1 && dout == 9'h100, "R2", "oe on third edge", {dout_oe, dout}, {1'b1, 9'h100});
        tick(1); rd_n = 1; tick(4);
        rd_word(9'h101, "R4");
        rd_word(9'h102, "R4");
        check(empty_n == 0, "R4", "empty after draining", empty_n, 0);

        // R7 read while empty
        rd_n = 0; tick(3);
        check(dout_oe == 0, "R7", "oe on empty read", dout_oe, 0);
        tick(1); rd_n = 1; tick(4);
        wr_word(9'h0AA);
        rd_word(9'h0AA, "R7");

        // R5 / R6 fill
        do_reset();
        for (int i = 0; i < HALF; i++) wr_word(W'(9'h040 + i));
        check(half_n == 1, "R6", "half_n at exactly half", half_n, 1);
        din = W'(9'h040 + HALF); wr_n = 0; tick(3);
        check(half_n == 0, "R6", "half_n on write fall", half_n, 0);
        tick(1); wr_n = 1; tick(4);
        for (int i = HALF + 1; i < DEPTH - 1; i++) wr_word(W'(9'h040 + i));
        check(full_n == 1, "R5", "not full at depth-1", full_n, 1);
        wr_word(W'(9'h040 + DEPTH - 1));
        check(full_n == 0, "R5", "full at depth", full_n, 0);
        wr_word(9'h1FF);
        check(full_n == 0, "R7", "still full after extra write", full_n, 0);
        for (int i = 0; i < DEPTH; i++) begin
            rd_word(W'(9'h040 + i), "R7");
            if (i == 0) check(full_n == 1, "R5", "full released by read", full_n, 1);
            if (i == DEPTH - HALF - 2) check(half_n == 0, "R6", "half held above half", half_n, 0);
            if (i == DEPTH - HALF - 1) check(half_n == 1, "R6", "half released at half", half_n, 1);
        end
        check(empty_n == 0, "R7", "extra write not stored", empty_n, 0);

        // R8 retransmit replay
        do_reset();
        for (int i = 0; i < 5; i++) wr_word(W'(9'h0C0 + i));
        for (int i = 0; i < 3; i++) rd_word(W'(9'h0C0 + i), "R8");
        rt_n = 0; tick(4); rt_n = 1; tick(4);
        check(empty_n == 1, "R8", "not empty after rewind", empty_n, 1);
        for (int i = 0; i < 5; i++) rd_word(W'(9'h0C0 + i), "R8");
        check(empty_n == 0, "R8", "empty after replay", empty_n, 0);

        // R8 rewind re-evaluates half-full, ignores strobes
        do_reset();
        for (int i = 0; i < 10; i++) wr_word(W'(9'h0E0 + i));
        for (int i = 0; i < 10; i++) rd_word(W'(9'h0E0 + i), "R8");
        check(empty_n == 0 && half_n == 1, "R8", "drained before rewind", {empty_n, half_n}, 2'b01);
        rt_n = 0; tick(3);
        din = 9'h1EE; wr_n = 0; tick(3); wr_n = 1; tick(3);
        rt_n = 1; tick(5);
        check(half_n == 0 && empty_n == 1 && full_n == 1, "R8", "flags after rewind",
              {half_n, empty_n, full_n}, 3'b011);
        for (int i = 0; i < 10; i++) rd_word(W'(9'h0E0 + i), "R8");
        check(empty_n == 0, "R8", "strobe during rewind ignored", empty_n, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule